// File: doc/BRIEF.md
# Halt and Stop Standby Controller

This block decides when the core of a small remote-control transmitter controller may sleep, and when it must wake. A halt request comes with a 4-bit condition operand. A mode bit then picks one of two wait states. In the light state the core is frozen and the oscillator keeps running. In the deep state the oscillator is also gated. A deep-state request that arrives while the transmit down counter is still busy freezes the core at once. It gates the oscillator only after the counter has drained.

While the core waits, the block watches four release sources:
- timer completion;
- the level of the serial input;
- any line of the key I/O port;
- any line of the key input port.

Pin levels pass through a synchronizer before they are compared. A selected source that is met gives a one-cycle wake strobe, and execution resumes. An input condition that a configuration switch marks as unused gives a one-cycle reset request instead. A hang-up option also requests a reset in the deep state when the key I/O port looks unsafe.

Top module: `stby_ctrl`

## Requirements
- R1: After reset, `cpu_hold`, `osc_stop`, `wake` and `sys_rst` are all 0.
- R2: When `halt_req` is sampled high with `stop_sel`=0, `cpu_hold` is 1 from the next cycle and `osc_stop` stays 0.
- R3: When `halt_req` is sampled high with `stop_sel`=1 and `timer_busy`=0, `cpu_hold` and `osc_stop` are both 1 from the next cycle.
- R4: When `halt_req` is sampled high with `stop_sel`=1 and `timer_busy`=1, `cpu_hold` is 1 from the next cycle. `osc_stop` stays 0 until `timer_busy` is sampled 0, and is 1 in the cycle after that.
- R5: The operand bits have these meanings:
  - `halt_cond[2]`=1 enables timer completion (`timer_busy`=0) as a release.
  - `halt_cond[1:0]` picks one input release: 00 none, 01 serial input, 10 any key I/O line, 11 any key input line.
  - `halt_cond[3]` is the input level that counts: 1 is high, 0 is low.
  - A release occurs when either enabled source is met.
- R6: The key I/O condition is met only while `kio_in_mode`=1.
- R7: While `rot_ser`=1, a waiting core is always released, whatever the operand.
- R8: The `unused_cfg` switches are bit 0 for serial, bit 1 for key I/O and bit 2 for key input. If a condition marked unused is met during a wait, at the operand level, the block gives a one-cycle `sys_rst` and no `wake`. It then leaves the wait state.
- R9: With `hang_en`=1, the block gives a one-cycle `sys_rst` in the oscillator-stopped state if `kio_in_mode`=1 or if any key I/O line reads low. With all lines high and `kio_in_mode`=0, it stays stopped.
- R10: A release gives `wake` high for exactly one cycle. In that cycle `cpu_hold` and `osc_stop` are already 0.
- R11: An input level that changes during a wait produces `wake` after the third rising clock edge that follows the change, because of the two-stage synchronizer.
- R12: `wake` and `sys_rst` are never high together. A reset condition wins over a release in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | One-cycle request to enter a wait state |
| halt_cond | input | 4 | Release condition operand |
| stop_sel | input | 1 | 0 selects the light wait, 1 the oscillator-stopped wait |
| timer_busy | input | 1 | Transmit down counter is running |
| rot_ser | input | 1 | Serial-input rotate mode is selected |
| kio_in_mode | input | 1 | Key I/O port is in input mode |
| unused_cfg | input | 3 | Marks input conditions as unused (reset instead of wake) |
| hang_en | input | 1 | Enables the hang-up reset in the stopped state |
| ser_in | input | 1 | Serial input pin level (asynchronous) |
| kio_in | input | KIO_W | Key I/O pin levels (asynchronous) |
| ki_in | input | KI_W | Key input pin levels (asynchronous) |
| cpu_hold | output | 1 | Core execution is frozen |
| osc_stop | output | 1 | Oscillator gate request |
| wake | output | 1 | One-cycle release strobe |
| sys_rst | output | 1 | One-cycle system reset request |

## Verification
A wrong state register shows up at the ports in the cycle after the fault. Possible symptoms are a hold that never falls, an oscillator gate raised while the counter still runs, or a wake strobe lasting two cycles. A fault in the synchronizer or the condition decode shows up as a strobe one cycle early or late, or as a strobe at the wrong level. A swapped priority shows up as a strobe on the wrong one of `wake` and `sys_rst`. Each scenario watches the ports in a window of several cycles. That window catches missing, doubled and misplaced strobes, not only final states.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_PEND = 2'd2,
    ST_STOP = 2'd3
  } stby_state_t;

  localparam int COND_W    = 4;
  localparam int POL_BIT   = 3;
  localparam int TMR_BIT   = 2;
  localparam logic [1:0] IN_NONE = 2'd0;
  localparam logic [1:0] IN_SER  = 2'd1;
  localparam logic [1:0] IN_KIO  = 2'd2;
  localparam logic [1:0] IN_KI   = 2'd3;
  localparam int UNU_SER = 0;
  localparam int UNU_KIO = 1;
  localparam int UNU_KI  = 2;
endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/stby_cond.sv
module stby_cond
  import stby_pkg::*;
#(
  parameter int KIO_W = 8,
  parameter int KI_W  = 4
) (
  input  logic [COND_W-1:0] cond,
  input  logic              timer_busy,
  input  logic              rot_ser,
  input  logic              kio_in_mode,
  input  logic [2:0]        unused_cfg,
  input  logic              hang_en,
  input  logic              ser_s,
  input  logic [KIO_W-1:0]  kio_s,
  input  logic [KI_W-1:0]   ki_s,
  output logic              rel_ok,
  output logic              bad_hit,
  output logic              hang_hit
);
  logic       pol;
  logic       ser_hit, kio_hit, ki_hit, in_hit;
  logic [2:0] hits;

  always_comb begin
    pol     = cond[POL_BIT];
    ser_hit = (ser_s == pol);
    kio_hit = kio_in_mode && (pol ? (|kio_s) : ~(&kio_s));
    ki_hit  = pol ? (|ki_s) : ~(&ki_s);
    hits    = '0;
    hits[UNU_SER] = ser_hit;
    hits[UNU_KIO] = kio_hit;
    hits[UNU_KI]  = ki_hit;
    unique case (cond[1:0])
      IN_SER:  in_hit = ser_hit;
      IN_KIO:  in_hit = kio_hit;
      IN_KI:   in_hit = ki_hit;
      default: in_hit = 1'b0;
    endcase
    rel_ok   = rot_ser || in_hit || (cond[TMR_BIT] && !timer_busy);
    bad_hit  = |(hits & unused_cfg);
    hang_hit = hang_en && (kio_in_mode || ~(&kio_s));
  end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  input  logic [COND_W-1:0] halt_cond,
  input  logic              stop_sel,
  input  logic              timer_busy,
  input  logic              rel_ok,
  input  logic              bad_hit,
  input  logic              hang_hit,
  output logic [COND_W-1:0] cond_q,
  output logic              cpu_hold,
  output logic              osc_stop,
  output logic              wake,
  output logic              sys_rst
);
  stby_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      cond_q  <= '0;
      wake    <= 1'b0;
      sys_rst <= 1'b0;
    end else begin
      wake    <= 1'b0;
      sys_rst <= 1'b0;
      if (state_q == ST_RUN) begin
        if (halt_req) begin
          cond_q  <= halt_cond;
          if (!stop_sel)       state_q <= ST_HALT;
          else if (timer_busy) state_q <= ST_PEND;
          else                 state_q <= ST_STOP;
        end
      end else if (bad_hit || (state_q == ST_STOP && hang_hit)) begin
        sys_rst <= 1'b1;
        state_q <= ST_RUN;
      end else if (rel_ok) begin
        wake    <= 1'b1;
        state_q <= ST_RUN;
      end else if (state_q == ST_PEND && !timer_busy) begin
        state_q <= ST_STOP;
      end
    end
  end

  assign cpu_hold = (state_q != ST_RUN);
  assign osc_stop = (state_q == ST_STOP);

  AST_HOLD_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !cpu_hold) |=> cpu_hold); // R2
  AST_OSC_AFTER_TIMER: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_stop) |-> !$past(timer_busy)); // R4
  AST_OSC_IMPLIES_HOLD: assert property (@(posedge clk) disable iff (rst)
    osc_stop |-> cpu_hold); // R3
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake); // R10
  AST_WAKE_FROM_HOLD: assert property (@(posedge clk) disable iff (rst)
    wake |-> ($past(cpu_hold) && !cpu_hold)); // R10
  AST_WAKE_XOR_RST: assert property (@(posedge clk) disable iff (rst)
    !(wake && sys_rst)); // R12
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int KIO_W       = 8,
  parameter int KI_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  input  logic [COND_W-1:0] halt_cond,
  input  logic              stop_sel,
  input  logic              timer_busy,
  input  logic              rot_ser,
  input  logic              kio_in_mode,
  input  logic [2:0]        unused_cfg,
  input  logic              hang_en,
  input  logic              ser_in,
  input  logic [KIO_W-1:0]  kio_in,
  input  logic [KI_W-1:0]   ki_in,
  output logic              cpu_hold,
  output logic              osc_stop,
  output logic              wake,
  output logic              sys_rst
);
  localparam int PIN_W = 1 + KIO_W + KI_W;

  logic [PIN_W-1:0]  pins_s;
  logic [COND_W-1:0] cond_q;
  logic              rel_ok, bad_hit, hang_hit;

  stby_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_in, kio_in, ki_in}),
    .q   (pins_s)
  );

  stby_cond #(.KIO_W(KIO_W), .KI_W(KI_W)) u_cond (
    .cond        (cond_q),
    .timer_busy  (timer_busy),
    .rot_ser     (rot_ser),
    .kio_in_mode (kio_in_mode),
    .unused_cfg  (unused_cfg),
    .hang_en     (hang_en),
    .ser_s       (pins_s[PIN_W-1]),
    .kio_s       (pins_s[KI_W +: KIO_W]),
    .ki_s        (pins_s[KI_W-1:0]),
    .rel_ok      (rel_ok),
    .bad_hit     (bad_hit),
    .hang_hit    (hang_hit)
  );

  stby_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .halt_req   (halt_req),
    .halt_cond  (halt_cond),
    .stop_sel   (stop_sel),
    .timer_busy (timer_busy),
    .rel_ok     (rel_ok),
    .bad_hit    (bad_hit),
    .hang_hit   (hang_hit),
    .cond_q     (cond_q),
    .cpu_hold   (cpu_hold),
    .osc_stop   (osc_stop),
    .wake       (wake),
    .sys_rst    (sys_rst)
  );
endmodule

// File: tb/tb_stby_ctrl.sv
`timescale 1ns/1ps
module tb_stby_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, halt_req, stop_sel, timer_busy, rot_ser, kio_in_mode, hang_en, ser_in;
  logic [3:0] halt_cond, ki_in;
  logic [2:0] unused_cfg;
  logic [7:0] kio_in;
  logic       cpu_hold, osc_stop, wake, sys_rst;

  stby_ctrl dut (.*);

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0] cond;
    logic       stop;
    logic       busy_t;
    logic       ser_t;
    logic [7:0] kio_t;
    logic [3:0] ki_t;
    logic       kmode;
    logic [2:0] unu;
    logic [1:0] outc;   // 0 held, 1 wake, 2 reset
    logic       osc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'b0100, 1'b0, 1'b0, 1'b1, 8'hFF, 4'hF, 1'b1, 3'b000, 2'd1, 1'b0}, // R5 timer
    '{4'b1001, 1'b0, 1'b1, 1'b1, 8'h00, 4'h0, 1'b1, 3'b000, 2'd1, 1'b0}, // R5 serial high
    '{4'b0001, 1'b0, 1'b1, 1'b0, 8'hFF, 4'hF, 1'b1, 3'b000, 2'd1, 1'b0}, // R5 serial low
    '{4'b1010, 1'b0, 1'b1, 1'b0, 8'h04, 4'h0, 1'b1, 3'b000, 2'd1, 1'b0}, // R5 key I/O
    '{4'b1010, 1'b0, 1'b1, 1'b0, 8'h04, 4'h0, 1'b0, 3'b000, 2'd0, 1'b0}, // R6 output mode
    '{4'b0011, 1'b0, 1'b1, 1'b1, 8'hFF, 4'hD, 1'b1, 3'b000, 2'd1, 1'b0}, // R5 key input low
    '{4'b1011, 1'b0, 1'b1, 1'b1, 8'h00, 4'h0, 1'b1, 3'b001, 2'd2, 1'b0}, // R8 serial unused
    '{4'b1001, 1'b0, 1'b1, 1'b1, 8'h00, 4'h0, 1'b1, 3'b001, 2'd2, 1'b0}, // R12 reset wins
    '{4'b0000, 1'b0, 1'b1, 1'b1, 8'hFF, 4'h7, 1'b1, 3'b100, 2'd2, 1'b0}, // R8 key input unused
    '{4'b1001, 1'b1, 1'b0, 1'b0, 8'h00, 4'h0, 1'b1, 3'b000, 2'd0, 1'b1}, // R4 stop after drain
    '{4'b1001, 1'b1, 1'b1, 1'b1, 8'h00, 4'h0, 1'b1, 3'b000, 2'd1, 1'b0}, // R4 wake from pending
    '{4'b0100, 1'b1, 1'b0, 1'b1, 8'hFF, 4'hF, 1'b1, 3'b000, 2'd1, 1'b0}, // R5 timer in stop
    '{4'b1001, 1'b0, 1'b1, 1'b0, 8'h00, 4'h0, 1'b1, 3'b000, 2'd0, 1'b0}, // R5 wrong level
    '{4'b1101, 1'b0, 1'b0, 1'b0, 8'h00, 4'h0, 1'b1, 3'b000, 2'd1, 1'b0}  // R5 timer or serial
  };

  task automatic set_idle(input logic pol);
    timer_busy = 1'b1;
    ser_in     = ~pol;
    kio_in     = {8{~pol}};
    ki_in      = {4{~pol}};
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic issue_halt(input logic [3:0] c, input logic s);
    halt_cond = c; stop_sel = s; halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
  endtask

  task automatic window(input int n, output int wk, output int rs);
    wk = 0; rs = 0;
    repeat (n) begin
      @(negedge clk);
      wk += int'(wake);
      rs += int'(sys_rst);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int wk, rs;
    rst = 1'b1; halt_req = 1'b0; halt_cond = '0; stop_sel = 1'b0; rot_ser = 1'b0;
    kio_in_mode = 1'b1; unused_cfg = '0; hang_en = 1'b0;
    set_idle(1'b1);
    do_reset();
    // R1 reset state
    check("R1 reset outputs", {4'b0, cpu_hold, osc_stop, wake, sys_rst}, 8'h00);

    // table of scenarios: R4 R5 R6 R8 R12
    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      set_idle(v.cond[3]);
      kio_in_mode = v.kmode; unused_cfg = v.unu;
      do_reset();
      issue_halt(v.cond, v.stop);
      timer_busy = v.busy_t; ser_in = v.ser_t; kio_in = v.kio_t; ki_in = v.ki_t;
      window(6, wk, rs);
      check($sformatf("R5/R8 vec%0d wake count", i), 8'(wk), (v.outc == 2'd1) ? 8'd1 : 8'd0);
      check($sformatf("R8/R12 vec%0d reset count", i), 8'(rs), (v.outc == 2'd2) ? 8'd1 : 8'd0);
      check($sformatf("R4/R6 vec%0d hold,osc", i), {6'b0, cpu_hold, osc_stop},
            {6'b0, (v.outc == 2'd0), v.osc});
    end

    // R2 light wait, then R11 latency and R10 strobe shape
    kio_in_mode = 1'b1; unused_cfg = '0; set_idle(1'b1);
    do_reset();
    issue_halt(4'b1001, 1'b0);
    check("R2 hold,osc after halt", {6'b0, cpu_hold, osc_stop}, 8'h02);
    ser_in = 1'b1;
    @(negedge clk); check("R11 no wake at 1", {7'b0, wake}, 8'h00);
    @(negedge clk); check("R11 no wake at 2", {7'b0, wake}, 8'h00);
    @(negedge clk); check("R11 wake at 3", {7'b0, wake}, 8'h01);
    check("R10 hold low with wake", {7'b0, cpu_hold}, 8'h00);
    @(negedge clk); check("R10 wake one cycle", {7'b0, wake}, 8'h00);

    // R3 stop with idle timer
    set_idle(1'b1); timer_busy = 1'b0;
    do_reset();
    issue_halt(4'b1001, 1'b1);
    check("R3 hold,osc stop", {6'b0, cpu_hold, osc_stop}, 8'h03);

    // R4 deferral timing
    set_idle(1'b1);
    do_reset();
    issue_halt(4'b1001, 1'b1);
    repeat (5) @(negedge clk);
    check("R4 pending hold,osc", {6'b0, cpu_hold, osc_stop}, 8'h02);
    timer_busy = 1'b0;
    @(negedge clk);
    check("R4 osc after drain", {6'b0, cpu_hold, osc_stop}, 8'h03);

    // R7 rotate mode always releases
    set_idle(1'b1); rot_ser = 1'b1;
    do_reset();
    issue_halt(4'b1001, 1'b0);
    window(4, wk, rs);
    check("R7 rotate release", 8'(wk), 8'd1);
    rot_ser = 1'b0;

    // R9 hang-up in stop
    set_idle(1'b1); timer_busy = 1'b0; kio_in = 8'hFF; kio_in_mode = 1'b0; hang_en = 1'b1;
    do_reset();
    issue_halt(4'b1001, 1'b1);
    window(5, wk, rs);
    check("R9 safe stop no reset", {6'b0, 2'(rs)}, 8'h00);
    check("R9 still stopped", {6'b0, cpu_hold, osc_stop}, 8'h03);
    kio_in = 8'hF7;
    window(6, wk, rs);
    check("R9 low line reset", 8'(rs), 8'd1);
    kio_in = 8'hFF; kio_in_mode = 1'b1;
    do_reset();
    issue_halt(4'b1001, 1'b1);
    window(4, wk, rs);
    check("R9 input mode reset", 8'(rs), 8'd1);
    check("R12 no wake with reset", 8'(wk), 8'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule